// File: doc/BRIEF.md
# Two-Register I2C Write Receiver

This block is the receive side of an I2C target that holds the setup and configuration state of a data-converter style peripheral. It samples the SCL and SDA wires through synchronisers, recognises START, repeated START and STOP conditions, and compares the first byte of a transfer with a fixed 7-bit address followed by a write direction bit. If the address matches and the direction is write, it acknowledges. It then accepts data bytes and acknowledges each one.

Each accepted data byte goes to one of two registers, selected by its top bit. A byte with the top bit set loads the setup fields: a 3-bit reference selector, an external-clock flag and a bipolar flag. A byte with the top bit clear loads the 7-bit configuration payload. A setup byte whose clear-request bit is 0 also returns the configuration payload to zero, while the setup fields still take the new values from that byte. The host may send one byte, two bytes or more in a single transfer, in any order. A byte that arrives later overwrites the register it selects. A parameter sets the target address.

Top module: `i2c_cfg_slave`

## Requirements
- R1: After reset, ref_sel is 0, ext_clk is 0, bipolar is 0, cfg_bits is 0 and sda_oe is 0.
- R2: A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. A START that arrives in the middle of a transfer (a repeated START) begins a new address phase.
- R3: When the first byte after a START equals {SLAVE_ADDR, 1'b0} (address in bits 7:1, direction bit 0 = write), the block pulls SDA low during the ninth SCL pulse.
- R4: If the address does not match, or the direction bit is 1, SDA stays released during the ninth pulse. Later bytes then get no acknowledge and change no register, until the next START or STOP.
- R5: A data byte with bit 7 = 1 loads ref_sel from bits 6:4, ext_clk from bit 3 and bipolar from bit 2. Bit 0 has no effect.
- R6: A data byte with bit 7 = 0 loads cfg_bits from bits 6:0 and leaves the setup fields unchanged.
- R7: A setup byte with bit 1 = 0 clears cfg_bits to 0 and still loads the new setup fields. With bit 1 = 1, cfg_bits is unchanged.
- R8: After a matched write address, every data byte is acknowledged and routed by its own bit 7, in any order. A later byte overwrites an earlier one.
- R9: sda_oe is asserted only during an acknowledge bit. After a STOP the block is idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| sda_oe | output | 1 | 1 = pull SDA low (acknowledge) |
| ref_sel | output | 3 | Reference selector setup field |
| ext_clk | output | 1 | 1 = external conversion clock selected |
| bipolar | output | 1 | 1 = bipolar input range |
| cfg_bits | output | 7 | Configuration register payload |

## Verification
The bench sends the two byte kinds in both orders and sends three-byte transfers. If routing were wrong, or a byte were dropped after the first one, cfg_bits or the setup fields would show the wrong value at the end.

Setup bytes are sent with the clear-request bit both 0 and 1. A design that cleared on the wrong polarity, or that also reset the setup fields, would show the wrong pair of values. A design that does not clear is caught when cfg_bits keeps its old value.

Wrong addresses, read-direction addresses and a repeated START after a rejected address are also tested. A design that acknowledges anyway, or that writes the bytes that follow, is caught both at the acknowledge sample and at the register outputs. A design that misses the repeated START never acknowledges the second address.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  localparam int BYTE_W = 8;
  localparam int CFG_W  = BYTE_W - 1;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_DATA, ST_DACK, ST_SKIP
  } rx_state_t;

  typedef struct packed {
    logic [2:0] ref_sel;
    logic       ext_clk;
    logic       bipolar;
  } setup_t;

  // top bit selects the destination register
  function automatic logic is_setup(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1];
  endfunction

  function automatic setup_t setup_of(input logic [BYTE_W-1:0] b);
    setup_t s;
    s.ref_sel = b[6:4];
    s.ext_clk = b[3];
    s.bipolar = b[2];
    return s;
  endfunction

  // bit 1 = 0 asks for the configuration register to be cleared
  function automatic logic keeps_cfg(input logic [BYTE_W-1:0] b);
    return b[1];
  endfunction

  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [ADDR_W-1:0] a);
    return (b[BYTE_W-1:1] == a) && !b[0];
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic [SYNC_STAGES-1:0] scl_chain, sda_chain;
  logic scl_d, sda_d, scl_s;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= scl_i;
          sda_chain <= sda_i;
        end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
          sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
        end
    end
  endgenerate

  assign scl_s = scl_chain[SYNC_STAGES-1];
  assign sda_s = sda_chain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign ev_start = scl_s & scl_d & sda_d & ~sda_s;
  assign ev_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx
  import i2c_cfg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'h34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              ev_start,
  input  logic              ev_stop,
  output logic              sda_oe,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_q,
  output rx_state_t         state
);
  logic [CNT_W-1:0] cnt;
  logic             full;

  assign full     = (cnt == CNT_W'(BYTE_W));
  assign byte_stb = (state == ST_DATA) && full && scl_fall && !ev_start && !ev_stop;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      byte_q <= '0;
      sda_oe <= 1'b0;
    end else if (ev_stop) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (ev_start) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_DATA: begin
          if (scl_rise && !full) begin
            byte_q <= {byte_q[BYTE_W-2:0], sda_s};
            cnt    <= cnt + 1'b1;
          end else if (scl_fall && full) begin
            cnt <= '0;
            if (state == ST_DATA) begin
              state  <= ST_DACK;
              sda_oe <= 1'b1;
            end else if (addr_hit(byte_q, SLAVE_ADDR)) begin
              state  <= ST_AACK;
              sda_oe <= 1'b1;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_AACK, ST_DACK: begin
          if (scl_fall) begin
            state  <= ST_DATA;
            sda_oe <= 1'b0;
          end
        end
        default: ;
      endcase
    end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import i2c_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_q,
  output setup_t            setup,
  output logic [CFG_W-1:0]  cfg,
  output logic              wr_setup,
  output logic              wr_cfg
);
  assign wr_setup = byte_stb &  is_setup(byte_q);
  assign wr_cfg   = byte_stb & ~is_setup(byte_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      setup <= '0;
      cfg   <= '0;
    end else if (wr_setup) begin
      setup <= setup_of(byte_q);
      if (!keeps_cfg(byte_q)) cfg <= '0;
    end else if (wr_cfg) begin
      cfg <= byte_q[CFG_W-1:0];
    end
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import i2c_cfg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SLAVE_ADDR  = 7'h34,
  parameter int                SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [2:0]       ref_sel,
  output logic             ext_clk,
  output logic             bipolar,
  output logic [CFG_W-1:0] cfg_bits
);
  // named internal events, observed by the bound checker
  logic              sda_s, scl_rise, scl_fall, ev_start, ev_stop;
  logic              byte_stb, wr_setup, wr_cfg;
  logic [BYTE_W-1:0] byte_q;
  rx_state_t         rx_state;
  setup_t            setup;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  i2c_byte_rx #(.SLAVE_ADDR(SLAVE_ADDR)) u_rx (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .ev_start(ev_start), .ev_stop(ev_stop),
    .sda_oe(sda_oe), .byte_stb(byte_stb), .byte_q(byte_q), .state(rx_state)
  );

  cfg_reg_bank u_regs (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_q(byte_q),
    .setup(setup), .cfg(cfg_bits), .wr_setup(wr_setup), .wr_cfg(wr_cfg)
  );

  assign ref_sel = setup.ref_sel;
  assign ext_clk = setup.ext_clk;
  assign bipolar = setup.bipolar;
endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk
  import i2c_cfg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe,
  input rx_state_t        rx_state,
  input logic             ev_start,
  input logic             ev_stop,
  input logic             byte_stb,
  input logic             wr_setup,
  input logic             wr_cfg,
  input logic [CFG_W-1:0] byte_lo,
  input logic [2:0]       ref_sel,
  input logic             ext_clk,
  input logic             bipolar,
  input logic [CFG_W-1:0] cfg_bits
);
  assert_ack_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (rx_state == ST_AACK || rx_state == ST_DACK));

  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!sda_oe && rx_state == ST_IDLE));

  assert_start_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && !ev_stop) |=> (rx_state == ST_ADDR));

  assert_skip_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_state == ST_SKIP) |-> (!sda_oe && !byte_stb));

  assert_one_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_setup, wr_cfg}));

  assert_byte_acked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> sda_oe);

  assert_setup_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_setup |=> $stable({ref_sel, ext_clk, bipolar}));

  assert_cfg_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> (cfg_bits == $past(byte_lo)));

  assert_cfg_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_setup && !byte_lo[1]) |=> (cfg_bits == '0));

  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cfg && !(wr_setup && !byte_lo[1])) |=> $stable(cfg_bits));
endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .rx_state(rx_state),
  .ev_start(ev_start), .ev_stop(ev_stop), .byte_stb(byte_stb),
  .wr_setup(wr_setup), .wr_cfg(wr_cfg), .byte_lo(byte_q[6:0]),
  .ref_sel(ref_sel), .ext_clk(ext_clk), .bipolar(bipolar), .cfg_bits(cfg_bits)
);

// File: tb/i2c_cfg_slave_bench.sv
module i2c_cfg_slave_bench;
  localparam logic [6:0] ADDR = 7'h34;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, ext_clk, bipolar;
  logic [2:0] ref_sel;
  logic [6:0] cfg_bits;
  wire sda_line = sda_m & ~sda_oe;
  int total = 0, bad = 0;
  logic oe_leak = 1'b0, done = 1'b0;

  always #5 clk = ~clk;

  i2c_cfg_slave #(.SLAVE_ADDR(ADDR)) u_i2c_cfg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .ref_sel(ref_sel), .ext_clk(ext_clk),
    .bipolar(bipolar), .cfg_bits(cfg_bits)
  );

  // vector: data byte, expected {ref,ext,bip}, expected cfg
  localparam logic [19:0] VEC [8] = '{
    {8'h55, 5'b00000, 7'h55}, {8'hDB, 5'b10110, 7'h55},
    {8'h7F, 5'b10110, 7'h7F}, {8'hA4, 5'b01001, 7'h00},
    {8'h01, 5'b01001, 7'h01}, {8'hF7, 5'b11101, 7'h01},
    {8'h8C, 5'b00011, 7'h00}, {8'h2A, 5'b00011, 7'h2A}
  };

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl_m = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic i2c_rstart();
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    sda_m = 1'b1; wclk(Q);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wclk(Q);
      scl_m = 1'b1; wclk(Q);
      if (sda_oe) oe_leak = 1'b1;
      scl_m = 1'b0; wclk(Q);
    end
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(Q/2);
    ack = !sda_line;
    wclk(Q/2);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic check_regs(input string tag, input logic [4:0] es, input logic [6:0] ec);
    check({tag, " setup"}, {27'd0, ref_sel, ext_clk, bipolar}, {27'd0, es});
    check({tag, " cfg"}, {25'd0, cfg_bits}, {25'd0, ec});
  endtask

  initial begin
    wclk(50000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    wclk(4);
    // R1 reset state
    check_regs("R1 reset", 5'b0, 7'h0);
    check("R1 sda_oe", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1; wclk(4);

    // table: one-byte writes, R3 address ack, R5/R6/R7 routing
    foreach (VEC[k]) begin
      i2c_start();
      send({ADDR, 1'b0}, ack);
      check("R3 addr ack", {31'd0, ack}, 32'd1);
      send(VEC[k][19:12], ack);
      check("R8 data ack", {31'd0, ack}, 32'd1);
      i2c_stop();
      check_regs("R5 R6 R7 vector", VEC[k][11:7], VEC[k][6:0]);
    end
    check("R9 no drive in data bits", {31'd0, oe_leak}, 32'd0);
    check("R9 released after stop", {31'd0, sda_oe}, 32'd0);

    // R8 setup then config in one transfer
    i2c_start(); send({ADDR, 1'b0}, ack);
    send(8'hC6, ack); check("R8 first ack", {31'd0, ack}, 32'd1);
    send(8'h33, ack); check("R8 second ack", {31'd0, ack}, 32'd1);
    i2c_stop();
    check_regs("R8 setup-then-cfg", 5'b10001, 7'h33);

    // R7 config then clearing setup byte
    i2c_start(); send({ADDR, 1'b0}, ack);
    send(8'h11, ack); send(8'hB0, ack);
    i2c_stop();
    check_regs("R7 cfg-then-clear", 5'b01100, 7'h00);

    // R8 three bytes, last overwrites
    i2c_start(); send({ADDR, 1'b0}, ack);
    send(8'h40, ack); send(8'hE2, ack); send(8'h05, ack);
    check("R8 third ack", {31'd0, ack}, 32'd1);
    i2c_stop();
    check_regs("R8 three bytes", 5'b11000, 7'h05);

    // R4 wrong address
    i2c_start(); send({7'h35, 1'b0}, ack);
    check("R4 wrong addr nack", {31'd0, ack}, 32'd0);
    send(8'h7E, ack);
    check("R4 ignored byte nack", {31'd0, ack}, 32'd0);
    i2c_stop();
    check_regs("R4 wrong addr no write", 5'b11000, 7'h05);

    // R4 read direction
    i2c_start(); send({ADDR, 1'b1}, ack);
    check("R4 read nack", {31'd0, ack}, 32'd0);
    send(8'h80, ack);
    i2c_stop();
    check_regs("R4 read no write", 5'b11000, 7'h05);

    // R2 repeated START inside a write
    i2c_start(); send({ADDR, 1'b0}, ack); send(8'h12, ack);
    i2c_rstart(); send({ADDR, 1'b0}, ack);
    check("R2 ack after Sr", {31'd0, ack}, 32'd1);
    send(8'h9E, ack);
    i2c_stop();
    check_regs("R2 repeated start", 5'b00111, 7'h12);

    // R2 R4 repeated START after a rejected address
    i2c_start(); send({7'h10, 1'b0}, ack);
    i2c_rstart(); send({ADDR, 1'b0}, ack);
    check("R2 recover ack", {31'd0, ack}, 32'd1);
    send(8'h0F, ack);
    i2c_stop();
    check_regs("R2 recover write", 5'b00111, 7'h0F);
    check("R9 final release", {31'd0, sda_oe}, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule